// File: doc/BRIEF.md
# Fail-First Vector Length Truncator

This block runs a vector operation's element loop in early-exit mode. A start pulse loads the vector length, the sub-group size, the stop mode and one predicate bit per sub-group. The block then takes one status flag per element through a valid/ready handshake. It walks the group index in the outer loop and the sub-offset in the inner loop. When it finishes, it pulses `done_o` and reports the resulting vector length, whether a real trap must be raised, and the group and sub-offset of the element that stopped the walk.

The block has two stop modes, and an operation uses exactly one of them.

- **Trap-stop:** the flag marks a fault. A fault in the first sub-group traps exactly as a scalar operation would. A fault in any later sub-group cancels that sub-group and everything after it. The vector length then shrinks to the number of whole sub-groups before the fault.
- **Condition-stop:** the flag marks a failed test. The walk ends at the first failing element, the length shrinks the same way, and no trap is ever raised.

A sub-group whose predicate bit is clear ignores its flags, but it still counts toward the new length.

Top module: `vl_truncator`

## Requirements
- R1: After reset, `done_o`, `elem_ready_o`, `trap_o` and `stop_o` are 0, and `vl_o`, `stop_idx_o` and `stop_sub_o` are 0.
- R2: When a start is accepted with nonzero length, `elem_ready_o` rises in the next cycle. Each cycle with `elem_valid_i` and `elem_ready_o` both high consumes one flag. Flags are taken in order of group, then sub-offset. In the cycle after the final consumed flag, `elem_ready_o` is 0 and `done_o` is 1 for exactly one cycle.
- R3: If no active element is flagged, `vl_o` equals `vl_i`, `stop_o` is 0, `trap_o` is 0, and exactly `vl_i` × sub-group-size flags are consumed.
- R4: With `mode_i`=0 (trap-stop), a flagged active element in group 0, at any sub-offset, sets `trap_o`=1 and `stop_o`=1 and leaves `vl_o`=`vl_i`. It also reports the sub-offset on `stop_sub_o` with `stop_idx_o`=0.
- R5: With `mode_i`=0, the first flagged active element in a group g>0 gives `trap_o`=0, `stop_o`=1 and `vl_o`=g. No further flags are consumed after it.
- R6: With `mode_i`=1 (condition-stop), the first flagged active element in any group g, including g=0, gives `vl_o`=g and `stop_o`=1. `trap_o` is never set in this mode.
- R7: Predicate bit g of `pred_i` gates all elements of group g. With the bit at 0, flags in that group are ignored, yet the group still counts toward `vl_o`.
- R8: With a sub-group size above 1, a group containing a flagged active element is excluded in full. `stop_idx_o` gives the group and `stop_sub_o` gives the offset inside it. A `subvl_i` of 0 acts as 1.
- R9: A start with `vl_i`=0 consumes no flags and gives `done_o`=1 in the next cycle with `vl_o`=0, `stop_o`=0 and `trap_o`=0.
- R10: `start_i` pulses while a walk is in progress are ignored, and the running walk's result is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a walk; honoured only when idle |
| vl_i | input | VL_W | Vector length in sub-groups (at most MAX_VL) |
| subvl_i | input | SUBVL_W | Elements per sub-group (0 treated as 1) |
| mode_i | input | 1 | 0 = trap-stop, 1 = condition-stop |
| pred_i | input | MAX_VL | Per-group predicate, bit g for group g |
| elem_valid_i | input | 1 | Element flag available |
| elem_flag_i | input | 1 | 1 = fault (trap-stop) or failed test (condition-stop) |
| elem_ready_o | output | 1 | Block accepts an element flag |
| done_o | output | 1 | One-cycle result strobe |
| vl_o | output | VL_W | Resulting vector length |
| trap_o | output | 1 | Raise a real trap |
| stop_o | output | 1 | Walk ended early on a flagged element |
| stop_idx_o | output | GRP_W | Group index of the stopping element |
| stop_sub_o | output | SUB_W | Sub-offset of the stopping element |

## Verification
The hardest case to reach is a flagged element sitting behind an earlier flag that must be ignored, with the handshake also stalling mid-walk. The earlier flag falls in a predicate-masked group or in a trailing position, and the stopping point lands at a non-zero sub-offset of a later group. The stimulus sweeps every single flag position across several lengths, sub-group sizes, predicate patterns and both modes. Some patterns add a second, later flag that must not win. Valid gaps are inserted at data-dependent beats, and a stray start is injected mid-walk in some runs.

// File: rtl/vl_trunc_pkg.sv
package vl_trunc_pkg;
  typedef enum logic {
    MODE_TRAP = 1'b0,
    MODE_COND = 1'b1
  } stop_mode_e;
endpackage

// File: rtl/vl_trunc_cursor.sv
module vl_trunc_cursor #(
  parameter int MAX_VL    = 8,
  parameter int MAX_SUBVL = 4,
  localparam int VL_W    = $clog2(MAX_VL + 1),
  localparam int GRP_W   = $clog2(MAX_VL),
  localparam int SUBVL_W = $clog2(MAX_SUBVL + 1),
  localparam int SUB_W   = (MAX_SUBVL > 1) ? $clog2(MAX_SUBVL) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               adv_i,
  input  logic [VL_W-1:0]    vl_i,
  input  logic [SUBVL_W-1:0] subvl_i,
  output logic [GRP_W-1:0]   grp_o,
  output logic [SUB_W-1:0]   sub_o,
  output logic               last_o
);
  logic [GRP_W-1:0] grp_q;
  logic [SUB_W-1:0] sub_q;
  logic             sub_last;
  logic             grp_last;

  assign sub_last = (SUBVL_W'(sub_q) + SUBVL_W'(1)) == subvl_i;
  assign grp_last = (VL_W'(grp_q) + VL_W'(1)) == vl_i;
  assign last_o   = sub_last && grp_last;
  assign grp_o    = grp_q;
  assign sub_o    = sub_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grp_q <= '0;
      sub_q <= '0;
    end else if (load_i) begin
      grp_q <= '0;
      sub_q <= '0;
    end else if (adv_i) begin
      if (sub_last) begin
        sub_q <= '0;
        grp_q <= grp_q + GRP_W'(1);
      end else begin
        sub_q <= sub_q + SUB_W'(1);
      end
    end
  end
endmodule

// File: rtl/vl_trunc_decide.sv
module vl_trunc_decide
  import vl_trunc_pkg::*;
(
  input  stop_mode_e mode_i,
  input  logic       pred_bit_i,
  input  logic       flag_i,
  input  logic       first_grp_i,
  output logic       hit_o,
  output logic       raise_o
);
  // masked groups never stop the walk
  assign hit_o   = flag_i && pred_bit_i;
  // only a trap-stop fault inside the first group becomes a real trap
  assign raise_o = hit_o && (mode_i == MODE_TRAP) && first_grp_i;
endmodule

// File: rtl/vl_truncator.sv
module vl_truncator
  import vl_trunc_pkg::*;
#(
  parameter int MAX_VL    = 8,
  parameter int MAX_SUBVL = 4,
  localparam int VL_W    = $clog2(MAX_VL + 1),
  localparam int GRP_W   = $clog2(MAX_VL),
  localparam int SUBVL_W = $clog2(MAX_SUBVL + 1),
  localparam int SUB_W   = (MAX_SUBVL > 1) ? $clog2(MAX_SUBVL) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [VL_W-1:0]    vl_i,
  input  logic [SUBVL_W-1:0] subvl_i,
  input  logic               mode_i,
  input  logic [MAX_VL-1:0]  pred_i,
  input  logic               elem_valid_i,
  input  logic               elem_flag_i,
  output logic               elem_ready_o,
  output logic               done_o,
  output logic [VL_W-1:0]    vl_o,
  output logic               trap_o,
  output logic               stop_o,
  output logic [GRP_W-1:0]   stop_idx_o,
  output logic [SUB_W-1:0]   stop_sub_o
);
  logic               busy_q;
  stop_mode_e         mode_q;
  logic [VL_W-1:0]    vl_cfg_q;
  logic [SUBVL_W-1:0] subvl_q;
  logic [MAX_VL-1:0]  pred_q;

  logic               done_q, trap_q, stop_q;
  logic [VL_W-1:0]    vl_q;
  logic [GRP_W-1:0]   idx_q;
  logic [SUB_W-1:0]   sub_q;

  logic               accept, beat, hit, raise, last;
  logic [GRP_W-1:0]   grp;
  logic [SUB_W-1:0]   sub;

  assign accept = start_i && !busy_q;
  assign beat   = busy_q && elem_valid_i;

  vl_trunc_cursor #(.MAX_VL(MAX_VL), .MAX_SUBVL(MAX_SUBVL)) u_cursor (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .adv_i   (beat),
    .vl_i    (vl_cfg_q),
    .subvl_i (subvl_q),
    .grp_o   (grp),
    .sub_o   (sub),
    .last_o  (last)
  );

  vl_trunc_decide u_decide (
    .mode_i      (mode_q),
    .pred_bit_i  (pred_q[grp]),
    .flag_i      (elem_flag_i),
    .first_grp_i (grp == '0),
    .hit_o       (hit),
    .raise_o     (raise)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      mode_q   <= MODE_TRAP;
      vl_cfg_q <= '0;
      subvl_q  <= SUBVL_W'(1);
      pred_q   <= '0;
      done_q   <= 1'b0;
      trap_q   <= 1'b0;
      stop_q   <= 1'b0;
      vl_q     <= '0;
      idx_q    <= '0;
      sub_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        mode_q   <= stop_mode_e'(mode_i);
        vl_cfg_q <= vl_i;
        subvl_q  <= (subvl_i == '0) ? SUBVL_W'(1) : subvl_i;
        pred_q   <= pred_i;
        if (vl_i == '0) begin
          done_q <= 1'b1;
          vl_q   <= '0;
          trap_q <= 1'b0;
          stop_q <= 1'b0;
          idx_q  <= '0;
          sub_q  <= '0;
        end else begin
          busy_q <= 1'b1;
        end
      end else if (beat && (hit || last)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        stop_q <= hit;
        trap_q <= raise;
        // truncate to whole groups before the stop; a real trap keeps length
        vl_q   <= (hit && !raise) ? VL_W'(grp) : vl_cfg_q;
        idx_q  <= hit ? grp : '0;
        sub_q  <= hit ? sub : '0;
      end
    end
  end

  assign elem_ready_o = busy_q;
  assign done_o       = done_q;
  assign vl_o         = vl_q;
  assign trap_o       = trap_q;
  assign stop_o       = stop_q;
  assign stop_idx_o   = idx_q;
  assign stop_sub_o   = sub_q;
endmodule

// File: rtl/vl_truncator_chk.sv
module vl_truncator_chk
  import vl_trunc_pkg::*;
#(
  parameter int MAX_VL    = 8,
  parameter int MAX_SUBVL = 4,
  localparam int VL_W    = $clog2(MAX_VL + 1),
  localparam int GRP_W   = $clog2(MAX_VL),
  localparam int SUB_W   = (MAX_SUBVL > 1) ? $clog2(MAX_SUBVL) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [VL_W-1:0]  vl_i,
  input logic             elem_ready_o,
  input logic             done_o,
  input logic [VL_W-1:0]  vl_o,
  input logic             trap_o,
  input logic             stop_o,
  input logic [GRP_W-1:0] stop_idx_o,
  input logic [VL_W-1:0]  vl_cfg_q,
  input stop_mode_e       mode_q
);
  a_r2_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r2_idle_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !elem_ready_o);
  a_r3_full_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !stop_o) |-> (vl_o == vl_cfg_q && !trap_o));
  a_r4_trap_first_group: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && trap_o) |-> (stop_idx_o == '0 && mode_q == MODE_TRAP && vl_o == vl_cfg_q));
  a_r5_truncate_to_group: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && stop_o && !trap_o) |-> (vl_o == VL_W'(stop_idx_o)));
  a_r6_cond_never_traps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && mode_q == MODE_COND) |-> !trap_o);
  a_r9_zero_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !elem_ready_o && vl_i == '0) |=> (done_o && vl_o == '0 && !stop_o));
  a_r10_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && elem_ready_o) |=> $stable(vl_cfg_q));
endmodule

bind vl_truncator vl_truncator_chk #(.MAX_VL(MAX_VL), .MAX_SUBVL(MAX_SUBVL)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .vl_i         (vl_i),
  .elem_ready_o (elem_ready_o),
  .done_o       (done_o),
  .vl_o         (vl_o),
  .trap_o       (trap_o),
  .stop_o       (stop_o),
  .stop_idx_o   (stop_idx_o),
  .vl_cfg_q     (vl_cfg_q),
  .mode_q       (mode_q)
);

// File: tb/vl_truncator_test.sv
module vl_truncator_test;
  localparam int MAX_VL = 8;
  localparam int MAX_SUBVL = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] vl_in = '0;
  logic [2:0] subvl_in = '0;
  logic       mode_in = 1'b0;
  logic [7:0] pred_in = '0;
  logic       valid = 1'b0;
  logic       flag = 1'b0;
  logic       ready, done, trap, stop;
  logic [3:0] vl_out;
  logic [2:0] idx_out;
  logic [1:0] sub_out;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  vl_truncator #(.MAX_VL(MAX_VL), .MAX_SUBVL(MAX_SUBVL)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .vl_i(vl_in),
    .subvl_i(subvl_in), .mode_i(mode_in), .pred_i(pred_in),
    .elem_valid_i(valid), .elem_flag_i(flag), .elem_ready_o(ready),
    .done_o(done), .vl_o(vl_out), .trap_o(trap), .stop_o(stop),
    .stop_idx_o(idx_out), .stop_sub_o(sub_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_op(input int vl, input int sv, input bit md,
                        input logic [7:0] pr, input logic [31:0] fm, input bit inject);
    int es, n, ehit, eg, esub, evl, ebeats, beats, guard;
    bit estop, etrap, gap;
    es = (sv == 0) ? 1 : sv;
    n = vl * es;
    ehit = -1;
    for (int e = 0; e < n; e++)
      if (ehit < 0 && fm[e] && pr[e / es]) ehit = e;
    estop = ehit >= 0;
    eg = estop ? ehit / es : 0;
    esub = estop ? ehit % es : 0;
    etrap = estop && !md && eg == 0;
    evl = (estop && !etrap) ? eg : vl;
    ebeats = estop ? ehit + 1 : n;

    @(negedge clk);
    start = 1'b1; vl_in = 4'(vl); subvl_in = 3'(sv); mode_in = md; pred_in = pr;
    @(negedge clk);
    start = 1'b0;
    beats = 0; guard = 0; gap = 1'b0;
    if (vl > 0) chk(ready == 1'b1, "R2 ready after start", int'(ready), 1);
    while (!done && guard < 300) begin
      if (ready) begin
        if (inject && beats == 1) begin
          start = 1'b1; vl_in = 4'd1; mode_in = ~md; pred_in = 8'h00;
        end
        if (((beats + vl + sv) % 4) == 3 && !gap) begin
          valid = 1'b0; gap = 1'b1;
        end else begin
          valid = 1'b1; flag = fm[beats]; beats++; gap = 1'b0;
        end
      end else valid = 1'b0;
      @(negedge clk);
      start = 1'b0;
      guard++;
    end
    valid = 1'b0; flag = 1'b0;
    chk(guard < 300, "R2 walk completes", guard, 0);
    chk(ready == 1'b0, "R2 ready low at done", int'(ready), 0);
    chk(beats == ebeats, estop ? "R5 flags consumed" : "R3 flags consumed", beats, ebeats);
    chk(int'(vl_out) == evl, md ? "R6 vl" : (etrap ? "R4 vl" : "R5 vl"), int'(vl_out), evl);
    chk(trap == etrap, md ? "R6 no trap" : "R4 trap", int'(trap), int'(etrap));
    chk(stop == estop, "R7 stop", int'(stop), int'(estop));
    if (estop) begin
      chk(int'(idx_out) == eg, "R8 stop group", int'(idx_out), eg);
      chk(int'(sub_out) == esub, "R8 stop sub-offset", int'(sub_out), esub);
    end
    if (inject) chk(int'(vl_out) == evl, "R10 stray start ignored", int'(vl_out), evl);
    @(negedge clk);
    chk(done == 1'b0, "R2 done one cycle", int'(done), 0);
  endtask

  initial begin
    #(8 * 190000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int vls[6] = '{0, 1, 2, 3, 5, 8};
    logic [7:0] prs[5] = '{8'hff, 8'h55, 8'haa, 8'h00, 8'h0e};
    #3;
    chk(done == 0 && ready == 0 && trap == 0 && stop == 0, "R1 reset flags", int'(done | ready | trap | stop), 0);
    chk(vl_out == 0 && idx_out == 0 && sub_out == 0, "R1 reset values", int'(vl_out), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // R9: zero-length start
    @(negedge clk);
    start = 1'b1; vl_in = 4'd0; subvl_in = 3'd2; mode_in = 1'b0; pred_in = 8'hff;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1 && ready == 1'b0, "R9 immediate done", int'(done), 1);
    chk(vl_out == 0 && stop == 0 && trap == 0, "R9 zero result", int'(vl_out), 0);
    foreach (vls[a]) begin
      for (int sv = 0; sv <= 4; sv++) begin
        for (int md = 0; md < 2; md++) begin
          foreach (prs[p]) begin
            int n;
            n = vls[a] * ((sv == 0) ? 1 : sv);
            for (int k = -1; k < n; k++) begin
              logic [31:0] fm;
              fm = (k < 0) ? 32'h0 : ((32'h1 << k) | ((k % 3 == 0) ? (32'h1 << (n - 1)) : 32'h0));
              run_op(vls[a], sv, md[0], prs[p], fm, (k % 7) == 2);
            end
          end
        end
      end
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule